// File: doc/BRIEF.md
# JTAG Indexed Register Access Port

This block is a test access port that gives a debugger, through a standard four-wire scan connection, access to a bank of on-chip registers. A 5-bit instruction register chooses which data register lies between the serial input `tdi` and the serial output `tdo`. The choices are an 8-bit power and reset control register, an 8-bit power and reset status register, a 32-bit identification code, a 1-bit bypass register, and an access path.

The access path is a pair of registers that take turns. Every data scan made under the access instruction switches between an 8-bit command register and a 32-bit data register. The command byte carries a 7-bit register index and a write flag. A command with the flag clear reads that register at once over a simple request/acknowledge bus, and the next data scan brings the value out. A command with the flag set arms a write, and the following data scan supplies the value and starts it. Scanning the command register out reports whether the bus is still busy, and whether an access was dropped because it was started while the bus was busy.

The whole block runs on the scan clock `tck` and has a synchronous active-high reset. The registers behind the bus and any crossing into another clock domain belong to the neighbouring logic.

Top module: `jtag_reg_port`

## Requirements
- R1: The controller follows the standard 16-state scan controller. From any state, five consecutive clocks with `tms` high reach Test-Logic-Reset, and it stays there while `tms` stays high.
- R2: The instruction register is 5 bits wide and is shifted least significant bit first. Capture-IR loads the pattern 5'b00001, so a scan shifts out 1 first and then four zeros.
- R3: Test-Logic-Reset selects instruction 0x1E. Under 0x1E, a 32-bit data scan shifts out the identification code 0x120034E5, least significant bit first.
- R4: Instruction 0x08 selects the 8-bit control register. Capture shifts out its current value, and Update-DR drives the shifted-in byte onto `pwr_ctl_o` (bit 0 core wakeup, bit 1 memory wakeup, bit 2 debug wakeup, bit 4 core reset, bit 6 debug reset, bit 7 debugger in use). No other event changes `pwr_ctl_o`.
- R5: Instruction 0x09 captures `pwr_stat_i` into the 8-bit scan path. An update under 0x09 changes neither `pwr_ctl_o` nor the bus.
- R6: Instruction 0x1F, and every code not named in R3 to R7, selects a 1-bit bypass register. It captures 0, so an 8-bit scan returns its input delayed by one position.
- R7: Under instruction 0x1C, the first data scan after Update-IR or Test-Logic-Reset uses the 8-bit command register, and each Update-DR switches to the other register of the pair. Capturing the command register loads bit 1 = busy and bit 0 = error, with all other bits 0.
- R8: An update of the command register with bit 0 clear starts a read of index bits 7:1. The bus shows `bus_req`=1, `bus_we`=0 and `bus_idx`=index one clock after Update-DR. The returned `bus_rdata` is the value the next data-register capture shifts out.
- R9: An update of the command register with bit 0 set starts nothing. A later update of the data register starts a write: `bus_we`=1, `bus_idx` set to the stored index and `bus_wdata` set to the 32 shifted-in bits.
- R10: While `bus_req` is high and `bus_ack` is low, `bus_req`, `bus_we`, `bus_idx` and `bus_wdata` hold their values. `bus_req` falls on the clock after `bus_ack` is sampled high, and the busy bit reads 1 until then.
- R11: An access started while busy is dropped and sets the error bit. The error bit is cleared by the command-register capture that reports it.
- R12: Synchronous reset puts the controller in Test-Logic-Reset, selects instruction 0x1E, clears `pwr_ctl_o`, the error bit and `bus_req`, and sets the pair to the command register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Scan clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| tms | input | 1 | Scan mode select |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, least significant bit of the selected path |
| pwr_stat_i | input | 8 | Power and reset status sampled at capture under 0x09 |
| pwr_ctl_o | output | 8 | Power and reset control register value |
| bus_req | output | 1 | Register bus request, held until acknowledged |
| bus_we | output | 1 | 1 for a write, 0 for a read |
| bus_idx | output | 7 | Register index of the access |
| bus_wdata | output | 32 | Write data |
| bus_ack | input | 1 | Completion from the register bank |
| bus_rdata | input | 32 | Read data, valid while `bus_ack` is high on a read |

## Verification
A behavioural model of the controller, the instruction and the register pair runs alongside the design and is compared with `tdo`, `pwr_ctl_o` and the bus outputs on every clock. Directed scans cover several cases. The identification, bypass and unknown-code scans check that the right path length and capture value are selected. Writing and reading back the control register, and then scanning the status register, shows whether an update reaches the right register and leaves the others alone. Reads with a short acknowledge delay show the read value being returned. A long delay lets a second command find the bus busy, which checks the busy report, the dropped access, the sticky error and its clearing. A final five-ones sequence after a different instruction checks that the identification code is selected again.

// File: rtl/jrp_pkg.sv
package jrp_pkg;

    localparam int IR_W = 5;

    localparam logic [IR_W-1:0] OP_PCTL   = 5'h08;
    localparam logic [IR_W-1:0] OP_PSTAT  = 5'h09;
    localparam logic [IR_W-1:0] OP_ACCESS = 5'h1C;
    localparam logic [IR_W-1:0] OP_IDCODE = 5'h1E;
    localparam logic [IR_W-1:0] OP_BYPASS = 5'h1F;
    localparam logic [IR_W-1:0] IR_CAPTURE = 5'b00001;

    typedef enum logic [3:0] {
        ST_RESET    = 4'd0,
        ST_IDLE     = 4'd1,
        ST_DR_SEL   = 4'd2,
        ST_DR_CAP   = 4'd3,
        ST_DR_SHIFT = 4'd4,
        ST_DR_EXIT1 = 4'd5,
        ST_DR_PAUSE = 4'd6,
        ST_DR_EXIT2 = 4'd7,
        ST_DR_UPD   = 4'd8,
        ST_IR_SEL   = 4'd9,
        ST_IR_CAP   = 4'd10,
        ST_IR_SHIFT = 4'd11,
        ST_IR_EXIT1 = 4'd12,
        ST_IR_PAUSE = 4'd13,
        ST_IR_EXIT2 = 4'd14,
        ST_IR_UPD   = 4'd15
    } tap_state_e;

    typedef enum logic [2:0] {
        SEL_BYP   = 3'd0,
        SEL_PCTL  = 3'd1,
        SEL_PSTAT = 3'd2,
        SEL_ADDR  = 3'd3,
        SEL_DATA  = 3'd4,
        SEL_ID    = 3'd5
    } dr_sel_e;

    typedef struct packed {
        logic busy;
        logic err;
    } acc_status_t;

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic tap_state_e tap_step(input tap_state_e s, input logic m);
        tap_state_e n;
        case (s)
            ST_RESET:    n = m ? ST_RESET    : ST_IDLE;
            ST_IDLE:     n = m ? ST_DR_SEL   : ST_IDLE;
            ST_DR_SEL:   n = m ? ST_IR_SEL   : ST_DR_CAP;
            ST_DR_CAP:   n = m ? ST_DR_EXIT1 : ST_DR_SHIFT;
            ST_DR_SHIFT: n = m ? ST_DR_EXIT1 : ST_DR_SHIFT;
            ST_DR_EXIT1: n = m ? ST_DR_UPD   : ST_DR_PAUSE;
            ST_DR_PAUSE: n = m ? ST_DR_EXIT2 : ST_DR_PAUSE;
            ST_DR_EXIT2: n = m ? ST_DR_UPD   : ST_DR_SHIFT;
            ST_DR_UPD:   n = m ? ST_DR_SEL   : ST_IDLE;
            ST_IR_SEL:   n = m ? ST_RESET    : ST_IR_CAP;
            ST_IR_CAP:   n = m ? ST_IR_EXIT1 : ST_IR_SHIFT;
            ST_IR_SHIFT: n = m ? ST_IR_EXIT1 : ST_IR_SHIFT;
            ST_IR_EXIT1: n = m ? ST_IR_UPD   : ST_IR_PAUSE;
            ST_IR_PAUSE: n = m ? ST_IR_EXIT2 : ST_IR_PAUSE;
            ST_IR_EXIT2: n = m ? ST_IR_UPD   : ST_IR_SHIFT;
            default:     n = m ? ST_DR_SEL   : ST_IDLE;
        endcase
        return n;
    endfunction

    function automatic dr_sel_e pick_dr(input logic [IR_W-1:0] code, input logic data_phase);
        dr_sel_e r;
        case (code)
            OP_PCTL:   r = SEL_PCTL;
            OP_PSTAT:  r = SEL_PSTAT;
            OP_ACCESS: r = data_phase ? SEL_DATA : SEL_ADDR;
            OP_IDCODE: r = SEL_ID;
            default:   r = SEL_BYP;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/jrp_tap_ctrl.sv
module jrp_tap_ctrl
    import jrp_pkg::*;
(
    input  logic       tck,
    input  logic       rst,
    input  logic       tms,
    output tap_state_e state
);

    tap_state_e st_q;

    always_ff @(posedge tck) begin
        if (rst) begin
            st_q <= ST_RESET;
        end else begin
            st_q <= tap_step(st_q, tms);
        end
    end

    assign state = st_q;

    // R1: a high tms keeps the controller in Test-Logic-Reset
    a_r1_reset_sticky: assert property (@(posedge tck) disable iff (rst)
        (st_q == ST_RESET && tms) |=> (st_q == ST_RESET));

    // R1: shift states are entered only through capture, exit2 or themselves
    a_r1_shift_entry: assert property (@(posedge tck) disable iff (rst)
        (st_q != ST_DR_CAP && st_q != ST_DR_EXIT2 && st_q != ST_DR_SHIFT) |=> (st_q != ST_DR_SHIFT));

endmodule

// File: rtl/jrp_ir.sv
module jrp_ir
    import jrp_pkg::*;
(
    input  logic            tck,
    input  logic            rst,
    input  tap_state_e      state,
    input  logic            tdi,
    output logic [IR_W-1:0] ir,
    output logic            ir_lsb
);

    logic [IR_W-1:0] ir_sh;
    logic [IR_W-1:0] ir_q;

    always_ff @(posedge tck) begin
        if (rst) begin
            ir_sh <= '0;
            ir_q  <= OP_IDCODE;
        end else begin
            case (state)
                ST_IR_CAP:   ir_sh <= IR_CAPTURE;
                ST_IR_SHIFT: ir_sh <= {tdi, ir_sh[IR_W-1:1]};
                default:     ir_sh <= ir_sh;
            endcase
            if (state == ST_RESET) begin
                ir_q <= OP_IDCODE;
            end else if (state == ST_IR_UPD) begin
                ir_q <= ir_sh;
            end
        end
    end

    assign ir     = ir_q;
    assign ir_lsb = ir_sh[0];

    // R2: the instruction changes only on Update-IR or Test-Logic-Reset
    a_r2_ir_hold: assert property (@(posedge tck) disable iff (rst)
        (state != ST_IR_UPD && state != ST_RESET) |=> $stable(ir));

    // R3: Test-Logic-Reset selects the identification code
    a_r3_reset_selects_id: assert property (@(posedge tck) disable iff (rst)
        (state == ST_RESET) |=> (ir == OP_IDCODE));

endmodule

// File: rtl/jrp_bus_agent.sv
module jrp_bus_agent #(
    parameter int IDX_W  = 7,
    parameter int DATA_W = 32
) (
    input  logic              tck,
    input  logic              rst,
    input  logic              start_rd,
    input  logic              start_wr,
    input  logic              err_clr,
    input  logic [IDX_W-1:0]  idx_in,
    input  logic [DATA_W-1:0] wdata_in,
    input  logic              bus_ack,
    output logic              bus_req,
    output logic              bus_we,
    output logic [IDX_W-1:0]  bus_idx,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              busy,
    output logic              err,
    output logic              rd_done
);

    logic              req_q;
    logic              we_q;
    logic              err_q;
    logic [IDX_W-1:0]  idx_q;
    logic [DATA_W-1:0] wdata_q;

    always_ff @(posedge tck) begin
        if (rst) begin
            req_q   <= 1'b0;
            we_q    <= 1'b0;
            err_q   <= 1'b0;
            idx_q   <= '0;
            wdata_q <= '0;
        end else begin
            if (req_q && bus_ack) begin
                req_q <= 1'b0;
            end
            if (err_clr) begin
                err_q <= 1'b0;
            end
            if (start_rd || start_wr) begin
                if (req_q) begin
                    err_q <= 1'b1;
                end else begin
                    req_q   <= 1'b1;
                    we_q    <= start_wr;
                    idx_q   <= idx_in;
                    wdata_q <= wdata_in;
                end
            end
        end
    end

    assign bus_req   = req_q;
    assign bus_we    = we_q;
    assign bus_idx   = idx_q;
    assign bus_wdata = wdata_q;
    assign busy      = req_q;
    assign err       = err_q;
    assign rd_done   = req_q && bus_ack && !we_q;

    // R10: an outstanding request holds its command until acknowledged
    a_r10_hold_until_ack: assert property (@(posedge tck) disable iff (rst)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_idx) && $stable(bus_we) && $stable(bus_wdata)));

    // R10: an acknowledge always ends the request
    a_r10_ack_ends: assert property (@(posedge tck) disable iff (rst)
        (bus_req && bus_ack) |=> (!bus_req || $past(start_rd || start_wr)));

endmodule

// File: rtl/jtag_reg_port.sv
module jtag_reg_port
    import jrp_pkg::*;
#(
    parameter int          IDX_W    = 7,
    parameter int          DATA_W   = 32,
    parameter int          PWR_W    = 8,
    parameter logic [31:0] ID_VALUE = 32'h120034E5
) (
    input  logic              tck,
    input  logic              rst,
    input  logic              tms,
    input  logic              tdi,
    output logic              tdo,
    input  logic [PWR_W-1:0]  pwr_stat_i,
    output logic [PWR_W-1:0]  pwr_ctl_o,
    output logic              bus_req,
    output logic              bus_we,
    output logic [IDX_W-1:0]  bus_idx,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ack,
    input  logic [DATA_W-1:0] bus_rdata
);

    localparam int CMD_W = IDX_W + 1;
    localparam int SH_W  = max_of(max_of(DATA_W, 32), max_of(CMD_W, PWR_W));
    localparam int LEN_W = $clog2(SH_W);

    tap_state_e       st;
    logic [IR_W-1:0]  ir;
    logic             ir_lsb;
    logic             access_phase;
    dr_sel_e          sel;

    logic [SH_W-1:0]  sh;
    logic [SH_W-1:0]  sh_nxt;
    logic [SH_W-1:0]  cap_val;
    logic [LEN_W-1:0] len_m1;

    logic [PWR_W-1:0]  pwr_ctl_q;
    logic [CMD_W-1:0]  cmd_q;
    logic [DATA_W-1:0] data_q;

    logic              is_cap_dr;
    logic              is_shift_dr;
    logic              is_upd_dr;
    logic              start_rd;
    logic              start_wr;
    logic              err_clr;
    logic              busy;
    logic              err;
    logic              rd_done;
    logic [IDX_W-1:0]  idx_sel;
    acc_status_t       status;

    jrp_tap_ctrl u_tap (
        .tck   (tck),
        .rst   (rst),
        .tms   (tms),
        .state (st)
    );

    jrp_ir u_ir (
        .tck    (tck),
        .rst    (rst),
        .state  (st),
        .tdi    (tdi),
        .ir     (ir),
        .ir_lsb (ir_lsb)
    );

    assign is_cap_dr   = (st == ST_DR_CAP);
    assign is_shift_dr = (st == ST_DR_SHIFT);
    assign is_upd_dr   = (st == ST_DR_UPD);

    // Address/data alternation under the access instruction
    always_ff @(posedge tck) begin
        if (rst || st == ST_RESET || st == ST_IR_UPD) begin
            access_phase <= 1'b0;
        end else if (is_upd_dr && ir == OP_ACCESS) begin
            access_phase <= ~access_phase;
        end
    end

    assign sel = pick_dr(ir, access_phase);

    // Path length and capture value of the selected register
    assign status = '{busy: busy, err: err};

    always_comb begin
        case (sel)
            SEL_PCTL: begin
                len_m1  = LEN_W'(PWR_W - 1);
                cap_val = SH_W'(pwr_ctl_q);
            end
            SEL_PSTAT: begin
                len_m1  = LEN_W'(PWR_W - 1);
                cap_val = SH_W'(pwr_stat_i);
            end
            SEL_ADDR: begin
                len_m1  = LEN_W'(CMD_W - 1);
                cap_val = SH_W'(status);
            end
            SEL_DATA: begin
                len_m1  = LEN_W'(DATA_W - 1);
                cap_val = SH_W'(data_q);
            end
            SEL_ID: begin
                len_m1  = LEN_W'(31);
                cap_val = SH_W'(ID_VALUE);
            end
            default: begin
                len_m1  = '0;
                cap_val = '0;
            end
        endcase
    end

    always_comb begin
        sh_nxt         = sh >> 1;
        sh_nxt[len_m1] = tdi;
    end

    always_ff @(posedge tck) begin
        if (rst) begin
            sh <= '0;
        end else if (is_cap_dr) begin
            sh <= cap_val;
        end else if (is_shift_dr) begin
            sh <= sh_nxt;
        end
    end

    assign tdo = (st == ST_IR_SHIFT) ? ir_lsb : sh[0];

    // Update paths
    always_ff @(posedge tck) begin
        if (rst) begin
            pwr_ctl_q <= '0;
            cmd_q     <= '0;
            data_q    <= '0;
        end else begin
            if (is_upd_dr && sel == SEL_PCTL) begin
                pwr_ctl_q <= sh[PWR_W-1:0];
            end
            if (is_upd_dr && sel == SEL_ADDR) begin
                cmd_q <= sh[CMD_W-1:0];
            end
            if (is_upd_dr && sel == SEL_DATA) begin
                data_q <= sh[DATA_W-1:0];
            end else if (rd_done) begin
                data_q <= bus_rdata;
            end
        end
    end

    assign pwr_ctl_o = pwr_ctl_q;

    assign start_rd = is_upd_dr && (sel == SEL_ADDR) && !sh[0];
    assign start_wr = is_upd_dr && (sel == SEL_DATA) && cmd_q[0];
    assign err_clr  = is_cap_dr && (sel == SEL_ADDR);
    assign idx_sel  = start_rd ? sh[CMD_W-1:1] : cmd_q[CMD_W-1:1];

    jrp_bus_agent #(
        .IDX_W  (IDX_W),
        .DATA_W (DATA_W)
    ) u_bus (
        .tck       (tck),
        .rst       (rst),
        .start_rd  (start_rd),
        .start_wr  (start_wr),
        .err_clr   (err_clr),
        .idx_in    (idx_sel),
        .wdata_in  (sh[DATA_W-1:0]),
        .bus_ack   (bus_ack),
        .bus_req   (bus_req),
        .bus_we    (bus_we),
        .bus_idx   (bus_idx),
        .bus_wdata (bus_wdata),
        .busy      (busy),
        .err       (err),
        .rd_done   (rd_done)
    );

    // R4: the control register moves only on its own update
    a_r4_ctl_hold: assert property (@(posedge tck) disable iff (rst)
        !(is_upd_dr && sel == SEL_PCTL) |=> $stable(pwr_ctl_o));

    // R8: a read command on an idle bus raises a read request
    a_r8_read_issue: assert property (@(posedge tck) disable iff (rst)
        (is_upd_dr && sel == SEL_ADDR && !sh[0] && !bus_req) |=> (bus_req && !bus_we));

    // R11: a command that finds the bus busy leaves the error bit set
    a_r11_busy_error: assert property (@(posedge tck) disable iff (rst)
        (is_upd_dr && sel == SEL_ADDR && !sh[0] && bus_req) |=> err);

    // R5: an update under the status instruction starts no bus access
    a_r5_status_quiet: assert property (@(posedge tck) disable iff (rst)
        (is_upd_dr && sel == SEL_PSTAT && !bus_req) |=> !bus_req);

endmodule

// File: tb/sim_jtag_reg_port.sv
`timescale 1ns/1ps
module sim_jtag_reg_port;

    logic        tck = 1'b0;
    logic        rst = 1'b1;
    logic        tms = 1'b1;
    logic        tdi = 1'b0;
    logic        tdo;
    logic [7:0]  pwr_stat_i = 8'h00;
    logic [7:0]  pwr_ctl_o;
    logic        bus_req;
    logic        bus_we;
    logic [6:0]  bus_idx;
    logic [31:0] bus_wdata;
    logic        bus_ack = 1'b0;
    logic [31:0] bus_rdata = 32'h0;

    int checks = 0;
    int errors = 0;
    int lat = 3;
    int ack_cnt = 0;
    int cyc = 0;

    always #2 tck = ~tck;

    jtag_reg_port u0 (
        .tck        (tck),
        .rst        (rst),
        .tms        (tms),
        .tdi        (tdi),
        .tdo        (tdo),
        .pwr_stat_i (pwr_stat_i),
        .pwr_ctl_o  (pwr_ctl_o),
        .bus_req    (bus_req),
        .bus_we     (bus_we),
        .bus_idx    (bus_idx),
        .bus_wdata  (bus_wdata),
        .bus_ack    (bus_ack),
        .bus_rdata  (bus_rdata)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // Register bank stand-in: acknowledges after lat cycles
    always @(posedge tck) begin
        if (rst) begin
            bus_ack <= 1'b0;
            ack_cnt <= 0;
        end else if (bus_ack) begin
            bus_ack <= 1'b0;
            ack_cnt <= 0;
        end else if (bus_req) begin
            if (ack_cnt >= lat) begin
                bus_ack   <= 1'b1;
                bus_rdata <= 32'hC0DE0000 | {25'h0, bus_idx};
            end else begin
                ack_cnt <= ack_cnt + 1;
            end
        end
    end

    // ---------------- behavioural reference model ----------------
    localparam int T_RST = 0, T_RTI = 1, T_SDR = 2, T_CDR = 3, T_SHDR = 4, T_E1DR = 5,
                   T_PDR = 6, T_E2DR = 7, T_UDR = 8, T_SIR = 9, T_CIR = 10, T_SHIR = 11,
                   T_E1IR = 12, T_PIR = 13, T_E2IR = 14, T_UIR = 15;

    int          m_st = T_RST;
    logic [4:0]  m_ir = 5'h1E;
    logic [4:0]  m_irsh = 5'h0;
    logic [31:0] m_sh = 32'h0;
    logic        m_phase = 1'b0;
    logic [7:0]  m_pctl = 8'h0;
    logic [7:0]  m_cmd = 8'h0;
    logic [31:0] m_data = 32'h0;
    logic        m_req = 1'b0;
    logic        m_we = 1'b0;
    logic [6:0]  m_idx = 7'h0;
    logic [31:0] m_wdata = 32'h0;
    logic        m_err = 1'b0;

    // 0 bypass, 1 control, 2 status, 3 command, 4 data, 5 id
    function automatic int m_sel(input logic [4:0] code, input logic ph);
        if (code == 5'h08) return 1;
        if (code == 5'h09) return 2;
        if (code == 5'h1C) return ph ? 4 : 3;
        if (code == 5'h1E) return 5;
        return 0;
    endfunction

    function automatic int m_len(input int s);
        if (s == 0) return 1;
        if (s == 4 || s == 5) return 32;
        return 8;
    endfunction

    function automatic int m_next(input int s, input logic m);
        case (s)
            T_RST:  return m ? T_RST  : T_RTI;
            T_RTI:  return m ? T_SDR  : T_RTI;
            T_SDR:  return m ? T_SIR  : T_CDR;
            T_CDR:  return m ? T_E1DR : T_SHDR;
            T_SHDR: return m ? T_E1DR : T_SHDR;
            T_E1DR: return m ? T_UDR  : T_PDR;
            T_PDR:  return m ? T_E2DR : T_PDR;
            T_E2DR: return m ? T_UDR  : T_SHDR;
            T_UDR:  return m ? T_SDR  : T_RTI;
            T_SIR:  return m ? T_RST  : T_CIR;
            T_CIR:  return m ? T_E1IR : T_SHIR;
            T_SHIR: return m ? T_E1IR : T_SHIR;
            T_E1IR: return m ? T_UIR  : T_PIR;
            T_PIR:  return m ? T_E2IR : T_PIR;
            T_E2IR: return m ? T_UIR  : T_SHIR;
            default: return m ? T_SDR : T_RTI;
        endcase
    endfunction

    always @(posedge tck) begin
        if (rst) begin
            m_st = T_RST; m_ir = 5'h1E; m_irsh = 5'h0; m_sh = 32'h0; m_phase = 1'b0;
            m_pctl = 8'h0; m_cmd = 8'h0; m_data = 32'h0; m_req = 1'b0; m_we = 1'b0;
            m_idx = 7'h0; m_wdata = 32'h0; m_err = 1'b0;
        end else begin
            int  s;
            logic was_busy;
            logic go;
            logic go_we;
            logic [6:0] go_idx;
            s        = m_sel(m_ir, m_phase);
            was_busy = m_req;
            go       = 1'b0;
            go_we    = 1'b0;
            go_idx   = 7'h0;
            if (m_req && bus_ack) begin
                m_req = 1'b0;
                if (!m_we) m_data = bus_rdata;
            end
            case (m_st)
                T_RST: begin m_ir = 5'h1E; m_phase = 1'b0; end
                T_CIR: m_irsh = 5'b00001;
                T_SHIR: m_irsh = {tdi, m_irsh[4:1]};
                T_UIR: begin m_ir = m_irsh; m_phase = 1'b0; end
                T_CDR: begin
                    case (s)
                        1: m_sh = {24'h0, m_pctl};
                        2: m_sh = {24'h0, pwr_stat_i};
                        3: begin m_sh = {30'h0, was_busy, m_err}; m_err = 1'b0; end
                        4: m_sh = m_data;
                        5: m_sh = 32'h120034E5;
                        default: m_sh = 32'h0;
                    endcase
                end
                T_SHDR: begin
                    m_sh = m_sh >> 1;
                    m_sh[m_len(s)-1] = tdi;
                end
                T_UDR: begin
                    if (s == 1) m_pctl = m_sh[7:0];
                    if (s == 3) begin
                        m_cmd = m_sh[7:0];
                        if (!m_sh[0]) begin go = 1'b1; go_we = 1'b0; go_idx = m_sh[7:1]; end
                    end
                    if (s == 4) begin
                        m_data = m_sh;
                        if (m_cmd[0]) begin go = 1'b1; go_we = 1'b1; go_idx = m_cmd[7:1]; end
                    end
                    if (go) begin
                        if (was_busy) m_err = 1'b1;
                        else begin
                            m_req = 1'b1; m_we = go_we; m_idx = go_idx; m_wdata = m_sh;
                        end
                    end
                    if (m_ir == 5'h1C) m_phase = ~m_phase;
                end
                default: ;
            endcase
            m_st = m_next(m_st, tms);
        end
    end

    // Per-clock comparison, away from the active edge
    always @(negedge tck) begin
        if (!rst) begin
            int s;
            s = m_sel(m_ir, m_phase);
            chk("R4 control output", {24'h0, pwr_ctl_o}, {24'h0, m_pctl});
            chk("R10 request", {31'h0, bus_req}, {31'h0, m_req});
            if (m_req) begin
                chk("R8 direction", {31'h0, bus_we}, {31'h0, m_we});
                chk("R8 index", {25'h0, bus_idx}, {25'h0, m_idx});
                if (m_we) chk("R9 write data", bus_wdata, m_wdata);
            end
            if (m_st == T_SHIR) chk("R2 serial out", {31'h0, tdo}, {31'h0, m_irsh[0]});
            if (m_st == T_SHDR) begin
                case (s)
                    1: chk("R4 serial out", {31'h0, tdo}, {31'h0, m_sh[0]});
                    2: chk("R5 serial out", {31'h0, tdo}, {31'h0, m_sh[0]});
                    3: chk("R7 serial out", {31'h0, tdo}, {31'h0, m_sh[0]});
                    4: chk("R8 serial out", {31'h0, tdo}, {31'h0, m_sh[0]});
                    5: chk("R3 serial out", {31'h0, tdo}, {31'h0, m_sh[0]});
                    default: chk("R6 serial out", {31'h0, tdo}, {31'h0, m_sh[0]});
                endcase
            end
        end
    end

    // Watchdog
    always @(posedge tck) begin
        cyc++;
        if (cyc == 150000) begin
            errors++;
            $display("FAIL R1 watchdog: actual %0d cycles expected fewer", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    task automatic step(input logic t, input logic d);
        @(negedge tck);
        tms = t;
        tdi = d;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0);
    endtask

    task automatic ir_scan(input logic [4:0] din, output logic [4:0] dout);
        dout = '0;
        step(1'b1, 1'b0);
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
        for (int i = 0; i < 5; i++) begin
            step(i == 4, din[i]);
            dout[i] = tdo;
        end
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
    endtask

    task automatic dr_scan(input int n, input logic [31:0] din, output logic [31:0] dout);
        dout = '0;
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
        for (int i = 0; i < n; i++) begin
            step(i == n - 1, din[i]);
            dout[i] = tdo;
        end
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
    endtask

    initial begin
        logic [4:0]  iro;
        logic [31:0] o;

        repeat (4) @(negedge tck);
        rst = 1'b0;
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);

        // R12: reset values
        chk("R12 control after reset", {24'h0, pwr_ctl_o}, 32'h0);
        chk("R12 request after reset", {31'h0, bus_req}, 32'h0);

        // R3: identification code selected after reset
        dr_scan(32, 32'h0, o);
        chk("R3 identification code", o, 32'h120034E5);

        // R2: instruction capture pattern
        ir_scan(5'h1F, iro);
        chk("R2 instruction capture", {27'h0, iro}, 32'h1);

        // R6: bypass and an unknown code
        dr_scan(8, 32'hA5, o);
        chk("R6 bypass delay", o, 32'h4A);
        ir_scan(5'h03, iro);
        dr_scan(8, 32'h3C, o);
        chk("R6 unknown code acts as bypass", o, 32'h78);

        // R4: control register write and read back
        ir_scan(5'h08, iro);
        dr_scan(8, 32'hD7, o);
        chk("R4 control capture of reset value", o, 32'h0);
        idle(1);
        chk("R4 control output after update", {24'h0, pwr_ctl_o}, 32'hD7);
        dr_scan(8, 32'h01, o);
        chk("R4 control read back", o, 32'hD7);
        idle(1);
        chk("R4 control output second update", {24'h0, pwr_ctl_o}, 32'h01);

        // R5: status capture, update has no effect
        pwr_stat_i = 8'h5C;
        ir_scan(5'h09, iro);
        dr_scan(8, 32'hFF, o);
        chk("R5 status capture", o, 32'h5C);
        idle(2);
        chk("R5 control untouched by status update", {24'h0, pwr_ctl_o}, 32'h01);
        chk("R5 no bus access from status update", {31'h0, bus_req}, 32'h0);

        // R7/R8: read with short acknowledge delay
        ir_scan(5'h1C, iro);
        dr_scan(8, {7'h15, 1'b0}, o);
        chk("R7 idle status capture", o, 32'h0);
        idle(1);
        chk("R8 read request", {31'h0, bus_req}, 32'h1);
        chk("R8 read direction", {31'h0, bus_we}, 32'h0);
        chk("R8 read index", {25'h0, bus_idx}, 32'h15);
        idle(10);
        chk("R10 request ends after acknowledge", {31'h0, bus_req}, 32'h0);
        dr_scan(32, 32'h0, o);
        chk("R8 read data returned", o, 32'hC0DE0015);

        // R10/R11: long acknowledge delay, second command while busy
        lat = 100;
        dr_scan(8, {7'h03, 1'b0}, o);
        chk("R7 status before long read", o, 32'h0);
        dr_scan(32, 32'h0, o);
        dr_scan(8, {7'h04, 1'b0}, o);
        chk("R10 busy reported", o, 32'h2);
        idle(1);
        chk("R11 dropped access keeps index", {25'h0, bus_idx}, 32'h03);
        chk("R10 request still held", {31'h0, bus_req}, 32'h1);
        dr_scan(32, 32'h0, o);
        for (int i = 0; i < 200 && bus_req; i++) idle(1);
        idle(2);
        lat = 3;
        dr_scan(8, {7'h00, 1'b1}, o);
        chk("R11 error reported", o, 32'h1);
        idle(2);
        chk("R9 write command starts nothing", {31'h0, bus_req}, 32'h0);
        dr_scan(32, 32'hCAFEF00D, o);
        chk("R8 first read value survived", o, 32'hC0DE0003);
        idle(1);
        chk("R9 write request", {31'h0, bus_req}, 32'h1);
        chk("R9 write direction", {31'h0, bus_we}, 32'h1);
        chk("R9 write index", {25'h0, bus_idx}, 32'h00);
        chk("R9 write data", bus_wdata, 32'hCAFEF00D);
        idle(10);
        dr_scan(8, {7'h00, 1'b1}, o);
        chk("R11 error cleared after report", o, 32'h0);

        // R1/R3: five ones from idle reach reset and reselect the identification code
        ir_scan(5'h08, iro);
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        dr_scan(32, 32'h0, o);
        chk("R1 five ones return to reset", o, 32'h120034E5);
        idle(1);
        chk("R12 control kept through controller reset", {24'h0, pwr_ctl_o}, 32'h01);

        idle(4);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule